// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Register Block

This block is a watchdog timer that software reaches through a 32-byte window on a simple 16-bit register bus. A 10-bit count is loaded from a programmable start value and moves down by one on every slow tick. A built-in prescaler makes that tick from the core clock, and its period is the parameter `TICK_DIV`, so a bench can shorten it. When the count runs out for the first time, the block sets a timeout flag, reloads the count and raises either an SMI pulse or an NMI pulse. Which of the two it raises depends on the SMI-routing input. If the count runs out a second time with no servicing in between, the block records a second-timeout and a boot status. It then requests a system reset, unless the no-reboot strap is set. With the strap set, it pulses and keeps running.

Software services the watchdog by writing any value to the count word. That write reloads the count, restarts the tick phase and forgets an earlier first timeout. The control word holds a halt bit and a sticky lock bit. The lock bit is brought out so that neighbouring SMI-enable logic can freeze its watchdog-enable bit. A mailbox byte lets software raise an SMI. A second mailbox byte only flags status.

The bus uses a word index `bus_word` (byte offset / 2) and two byte enables. Lane 0 is the even byte and lane 1 is the odd byte. Reads are combinational. Writes take effect on the clock edge where `bus_wr` is high.

Top module: `wdt_regblock`

## Requirements
- R1: After reset, these words read as follows: start value (word 9) 0x0004, control2 (word 5) 0x0008, software-IRQ byte (word 8) 0x0003. Every other word reads 0x0000, including the unmapped words 10 to 15. `smi_pulse`, `nmi_pulse`, `reset_req` and `lock_out` are all low.
- R2: Each word is written only in the byte lanes whose enable is set. Word 1 holds mailbox-in (lane 0) and mailbox-out (lane 1). Word 6 holds message bytes 1 (lane 0) and 2 (lane 1). Word 7 lane 0 holds the watchdog-count byte, and its lane 1 reads 0.
- R3: Stored values are masked as follows: control1 (word 4) with 0xFEFF, status1 (word 2) with 0xE870, status2 (word 3) with 0xFFF8, and the start value with 0x03FF.
- R4: The timer can run only when control1 bit 11 (halt) is 0 and the start value is above 1. A start value of 0 or 1 keeps it stopped, so no pulse occurs and the count does not change.
- R5: Any write to word 0 while the run condition holds loads the count from the start value and restarts the tick phase. While the run condition is false, the written value (low 10 bits) becomes the count.
- R6: Once running, the count drops by one every `TICK_DIV` cycles. The first expiry lands `start*TICK_DIV` edges after the reload edge. On that edge the block sets status1 bit 3 and reloads the count. In the following cycle it gives a one-cycle SMI pulse if `smi_route_en` is 1, or a one-cycle NMI pulse if it is 0.
- R7: On the second expiry without servicing, the block sets status2 bits 1 and 2. With `strap_noreboot` at 0, it stops the timer and raises `reset_req`, which stays high until reset, and it gives no SMI or NMI pulse. With the strap at 1, it pulses and reloads as on a first expiry.
- R8: A service write to word 0 while the run condition holds clears the record of an earlier expiry. The next expiry therefore counts as a first one.
- R9: Control1 bit 12 (lock) can be set by a write but is not cleared by any later write, only by reset. `lock_out` shows its value.
- R10: Every control1 write checks the run condition again with the new value. If the timer can run, the count reloads and the tick phase restarts. If it cannot, the timer stops and the count holds.
- R11: A lane-0 write to word 1 stores the byte, sets status1 bit 1 and gives an SMI pulse in the next cycle. A lane-1 write to word 1 stores the byte and sets status1 bit 2, with no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_word | input | 4 | Word index within the window (byte offset / 2) |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_be | input | 2 | Byte-lane enables (bit 0 is the even byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_word`, combinational |
| strap_noreboot | input | 1 | When 1, a second expiry does not request a reset |
| smi_route_en | input | 1 | When 1, an expiry raises SMI; when 0, it raises NMI |
| smi_pulse | output | 1 | One-cycle SMI request |
| nmi_pulse | output | 1 | One-cycle NMI request |
| reset_req | output | 1 | System reset request, held until reset |
| lock_out | output | 1 | Current value of the lock bit |

## Verification
Read data depends only on the current state and `bus_word`, so the bench samples it one time unit after setting the index. This happens in the low phase of the clock. Register writes and the mailbox SMI pulse show up at the falling edge straight after the write edge. An expiry pulse is due exactly `start*TICK_DIV` falling edges after the write that started the timer. The bench checks that the pulse is low one cycle earlier and high on the due cycle, and reads the decremented count at the first tick. The second-stage and servicing cases are timed from the same reference edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int WORD_W    = 16;
    localparam int NUM_WORDS = 10;

    typedef enum logic [3:0] {
        W_COUNT = 4'd0,
        W_MAIL  = 4'd1,
        W_STS1  = 4'd2,
        W_STS2  = 4'd3,
        W_CTL1  = 4'd4,
        W_CTL2  = 4'd5,
        W_MSG   = 4'd6,
        W_WDC   = 4'd7,
        W_SWIRQ = 4'd8,
        W_INIT  = 4'd9
    } word_e;

    localparam logic [WORD_W-1:0] CTL1_WMASK = 16'hFEFF;
    localparam logic [WORD_W-1:0] STS1_WMASK = 16'hE870;
    localparam logic [WORD_W-1:0] STS2_WMASK = 16'hFFF8;

    localparam int CTL1_HALT   = 11;
    localparam int CTL1_LOCK   = 12;
    localparam int STS1_SWSMI  = 1;
    localparam int STS1_MBOUT  = 2;
    localparam int STS1_TMO    = 3;
    localparam int STS2_SECOND = 1;
    localparam int STS2_BOOT   = 2;

    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] old_v,
        input logic [WORD_W-1:0] new_v,
        input logic [1:0]        be
    );
        return {be[1] ? new_v[15:8] : old_v[15:8],
                be[0] ? new_v[7:0]  : old_v[7:0]};
    endfunction

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int TICK_DIV = 150_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_comb begin
        if (restart || !run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/wdt_read_mux.sv
module wdt_read_mux #(
    parameter int NW = 10,
    parameter int DW = 16
) (
    input  logic [NW-1:0][DW-1:0] words,
    input  logic [3:0]            sel,
    output logic [DW-1:0]         rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NW; i++) begin
            if (sel == 4'(i)) begin
                rdata = words[i];
            end
        end
    end
endmodule

// File: rtl/wdt_regblock.sv
module wdt_regblock
    import wdt_pkg::*;
#(
    parameter int TICK_DIV = 150_000_000,
    parameter int CNT_W    = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_word,
    input  logic        bus_wr,
    input  logic [1:0]  bus_be,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        strap_noreboot,
    input  logic        smi_route_en,
    output logic        smi_pulse,
    output logic        nmi_pulse,
    output logic        reset_req,
    output logic        lock_out
);
    localparam int PAD_W = WORD_W - CNT_W;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  start;
        logic [7:0]        mbox_in;
        logic [7:0]        mbox_out;
        logic [WORD_W-1:0] sts1;
        logic [WORD_W-1:0] sts2;
        logic [WORD_W-1:0] ctl1;
        logic [WORD_W-1:0] ctl2;
        logic [7:0]        msg_a;
        logic [7:0]        msg_b;
        logic [7:0]        wdc;
        logic [7:0]        swirq;
        logic              expired_once;
        logic              running;
        logic              smi;
        logic              nmi;
        logic              rst_req;
    } state_t;

    localparam state_t RESET_STATE = '{
        count:        '0,
        start:        CNT_W'(4),
        mbox_in:      8'h00,
        mbox_out:     8'h00,
        sts1:         16'h0000,
        sts2:         16'h0000,
        ctl1:         16'h0000,
        ctl2:         16'h0008,
        msg_a:        8'h00,
        msg_b:        8'h00,
        wdc:          8'h00,
        swirq:        8'h03,
        expired_once: 1'b0,
        running:      1'b0,
        smi:          1'b0,
        nmi:          1'b0,
        rst_req:      1'b0
    };

    state_t q, d;
    logic   tick;
    logic   restart;

    logic [NUM_WORDS-1:0][WORD_W-1:0] words;

    function automatic logic can_run(input logic [WORD_W-1:0] ctl,
                                     input logic [CNT_W-1:0]  start_v);
        return !ctl[CTL1_HALT] && (start_v > CNT_W'(1));
    endfunction

    wdt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (q.running),
        .restart (restart),
        .tick    (tick)
    );

    always_comb begin
        logic [WORD_W-1:0] merged;
        logic [WORD_W-1:0] new_ctl;

        d       = q;
        d.smi   = 1'b0;
        d.nmi   = 1'b0;
        restart = 1'b0;
        merged  = '0;
        new_ctl = '0;

        if (bus_wr) begin
            unique case (bus_word)
                W_COUNT: begin
                    if (can_run(q.ctl1, q.start)) begin
                        d.count        = q.start;
                        d.running      = 1'b1;
                        d.expired_once = 1'b0;
                        restart        = 1'b1;
                    end else begin
                        merged  = lane_merge({{PAD_W{1'b0}}, q.count}, bus_wdata, bus_be);
                        d.count = merged[CNT_W-1:0];
                    end
                end
                W_MAIL: begin
                    if (bus_be[0]) begin
                        d.mbox_in          = bus_wdata[7:0];
                        d.sts1[STS1_SWSMI] = 1'b1;
                        d.smi              = 1'b1;
                    end
                    if (bus_be[1]) begin
                        d.mbox_out         = bus_wdata[15:8];
                        d.sts1[STS1_MBOUT] = 1'b1;
                    end
                end
                W_STS1: d.sts1 = lane_merge(q.sts1, bus_wdata, bus_be) & STS1_WMASK;
                W_STS2: d.sts2 = lane_merge(q.sts2, bus_wdata, bus_be) & STS2_WMASK;
                W_CTL1: begin
                    new_ctl = lane_merge(q.ctl1, bus_wdata, bus_be) & CTL1_WMASK;
                    new_ctl[CTL1_LOCK] = new_ctl[CTL1_LOCK] | q.ctl1[CTL1_LOCK];
                    d.ctl1 = new_ctl;
                    if (can_run(new_ctl, q.start)) begin
                        d.count   = q.start;
                        d.running = 1'b1;
                        restart   = 1'b1;
                    end else begin
                        d.running = 1'b0;
                    end
                end
                W_CTL2: d.ctl2 = lane_merge(q.ctl2, bus_wdata, bus_be);
                W_MSG: begin
                    if (bus_be[0]) d.msg_a = bus_wdata[7:0];
                    if (bus_be[1]) d.msg_b = bus_wdata[15:8];
                end
                W_WDC: begin
                    if (bus_be[0]) d.wdc = bus_wdata[7:0];
                end
                W_SWIRQ: begin
                    if (bus_be[0]) d.swirq = bus_wdata[7:0];
                end
                W_INIT: begin
                    merged  = lane_merge({{PAD_W{1'b0}}, q.start}, bus_wdata, bus_be);
                    d.start = merged[CNT_W-1:0];
                end
                default: ;
            endcase
        end

        // Count-down and expiry; a same-cycle restart or stop takes priority.
        if (tick && q.running && d.running && !restart) begin
            if (q.count <= CNT_W'(1)) begin
                d.sts1[STS1_TMO] = 1'b1;
                if (q.expired_once) begin
                    d.sts2[STS2_SECOND] = 1'b1;
                    d.sts2[STS2_BOOT]   = 1'b1;
                    d.expired_once      = 1'b0;
                    if (!strap_noreboot) begin
                        d.running = 1'b0;
                        d.rst_req = 1'b1;
                        d.count   = '0;
                    end else begin
                        d.count = q.start;
                        d.smi   = d.smi | smi_route_en;
                        d.nmi   = !smi_route_en;
                    end
                end else begin
                    d.expired_once = 1'b1;
                    d.count        = q.start;
                    d.smi          = d.smi | smi_route_en;
                    d.nmi          = !smi_route_en;
                end
            end else begin
                d.count = q.count - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET_STATE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        words          = '0;
        words[W_COUNT] = {{PAD_W{1'b0}}, q.count};
        words[W_MAIL]  = {q.mbox_out, q.mbox_in};
        words[W_STS1]  = q.sts1;
        words[W_STS2]  = q.sts2;
        words[W_CTL1]  = q.ctl1;
        words[W_CTL2]  = q.ctl2;
        words[W_MSG]   = {q.msg_b, q.msg_a};
        words[W_WDC]   = {8'h00, q.wdc};
        words[W_SWIRQ] = {8'h00, q.swirq};
        words[W_INIT]  = {{PAD_W{1'b0}}, q.start};
    end

    wdt_read_mux #(.NW(NUM_WORDS), .DW(WORD_W)) u_rmux (
        .words (words),
        .sel   (bus_word),
        .rdata (bus_rdata)
    );

    assign smi_pulse = q.smi;
    assign nmi_pulse = q.nmi;
    assign reset_req = q.rst_req;
    assign lock_out  = q.ctl1[CTL1_LOCK];

endmodule

// File: rtl/wdt_regblock_chk.sv
module wdt_regblock_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  bus_word,
    input logic        bus_wr,
    input logic [1:0]  bus_be,
    input logic        smi_route_en,
    input logic        smi_pulse,
    input logic        nmi_pulse,
    input logic        reset_req,
    input logic        lock_out
);
    // R7
    reset_req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> reset_req);

    // R7
    reset_no_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> !nmi_pulse);

    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_out |=> lock_out);

    // R11
    mailbox_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_word == 4'd1 && bus_be[0]) |=> smi_pulse);

    // R6
    nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |=> !nmi_pulse);

    // R6
    nmi_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_pulse) |-> !$past(smi_route_en));
endmodule

bind wdt_regblock wdt_regblock_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_word     (bus_word),
    .bus_wr       (bus_wr),
    .bus_be       (bus_be),
    .smi_route_en (smi_route_en),
    .smi_pulse    (smi_pulse),
    .nmi_pulse    (nmi_pulse),
    .reset_req    (reset_req),
    .lock_out     (lock_out)
);

// File: tb/sim_wdt_regblock.sv
`timescale 1ns/1ps
module sim_wdt_regblock;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_word = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        strap_noreboot = 1'b0;
    logic        smi_route_en = 1'b0;
    logic        smi_pulse, nmi_pulse, reset_req, lock_out;

    int checks = 0;
    int errors = 0;
    int pulses = 0;

    always #2 clk = ~clk;

    wdt_regblock #(.TICK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .strap_noreboot(strap_noreboot), .smi_route_en(smi_route_en),
        .smi_pulse(smi_pulse), .nmi_pulse(nmi_pulse),
        .reset_req(reset_req), .lock_out(lock_out)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  word;
        logic [1:0]  be;
        logic [15:0] data;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd9,  2'b11, 16'h0000, 16'h0004}, // R1 start value
        '{1'b0, 4'd5,  2'b11, 16'h0000, 16'h0008}, // R1 control2
        '{1'b0, 4'd8,  2'b11, 16'h0000, 16'h0003}, // R1 sw irq byte
        '{1'b0, 4'd0,  2'b11, 16'h0000, 16'h0000}, // R1 count
        '{1'b0, 4'd3,  2'b11, 16'h0000, 16'h0000}, // R1 status2
        '{1'b0, 4'd15, 2'b11, 16'h0000, 16'h0000}, // R1 unmapped
        '{1'b1, 4'd4,  2'b11, 16'h0B00, 16'h0000},
        '{1'b0, 4'd4,  2'b11, 16'h0000, 16'h0A00}, // R3 control1 mask
        '{1'b1, 4'd2,  2'b11, 16'hFFFF, 16'h0000},
        '{1'b0, 4'd2,  2'b11, 16'h0000, 16'hE870}, // R3 status1 mask
        '{1'b1, 4'd3,  2'b11, 16'hFFFF, 16'h0000},
        '{1'b0, 4'd3,  2'b11, 16'h0000, 16'hFFF8}, // R3 status2 mask
        '{1'b1, 4'd9,  2'b11, 16'hFFFF, 16'h0000},
        '{1'b0, 4'd9,  2'b11, 16'h0000, 16'h03FF}, // R3 start mask
        '{1'b1, 4'd6,  2'b01, 16'h1234, 16'h0000},
        '{1'b1, 4'd6,  2'b10, 16'hABCD, 16'h0000},
        '{1'b0, 4'd6,  2'b11, 16'h0000, 16'hAB34}, // R2 message lanes
        '{1'b1, 4'd7,  2'b11, 16'hBEEF, 16'h0000},
        '{1'b0, 4'd7,  2'b11, 16'h0000, 16'h00EF}, // R2 wd-count byte
        '{1'b1, 4'd0,  2'b11, 16'h0555, 16'h0000},
        '{1'b0, 4'd0,  2'b11, 16'h0000, 16'h0155}, // R5 halted store
        '{1'b1, 4'd4,  2'b01, 16'h00FF, 16'h0000},
        '{1'b0, 4'd4,  2'b11, 16'h0000, 16'h0AFF}  // R2 lane merge
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] w, input logic [1:0] be, input logic [15:0] dat);
        @(negedge clk);
        bus_word  = w;
        bus_be    = be;
        bus_wdata = dat;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] w, output logic [15:0] v);
        bus_word = w;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (smi_pulse || nmi_pulse) pulses++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic [15:0] held;
        do_reset();
        // R1 outputs after reset
        chk("R1 pulses/req/lock", {12'h0, smi_pulse, nmi_pulse, reset_req, lock_out}, 16'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                wr(VECS[i].word, VECS[i].be, VECS[i].data);
            end else begin
                @(negedge clk);
                rd(VECS[i].word, v);
                chk($sformatf("vector %0d word %0d", i, VECS[i].word), v, VECS[i].exp);
            end
        end

        // R6 / R7: first expiry routed to NMI, second requests reset
        do_reset();
        smi_route_en = 1'b0; strap_noreboot = 1'b0;
        wr(4'd4, 2'b11, 16'h0000);
        wait_n(DIV);
        rd(4'd0, v); chk("R6 count after one tick", v, 16'h0003);
        wait_n(4*DIV - DIV - 1);
        chk("R6 nmi not early", {15'h0, nmi_pulse}, 16'h0);
        wait_n(1);
        chk("R6 nmi on expiry", {15'h0, nmi_pulse}, 16'h1);
        chk("R6 no smi when routed to nmi", {15'h0, smi_pulse}, 16'h0);
        wait_n(1);
        chk("R6 nmi single cycle", {15'h0, nmi_pulse}, 16'h0);
        rd(4'd2, v); chk("R6 timeout status", v, 16'h0008);
        rd(4'd0, v); chk("R6 count reloaded", v, 16'h0004);
        wait_n(4*DIV - 1);
        chk("R7 reset request", {15'h0, reset_req}, 16'h1);
        chk("R7 no nmi with reset", {15'h0, nmi_pulse}, 16'h0);
        rd(4'd3, v); chk("R7 second/boot status", v, 16'h0006);
        pulses = 0;
        wait_n(20);
        chk("R7 reset held", {15'h0, reset_req}, 16'h1);
        chk("R7 timer stopped", pulses[15:0], 16'h0);

        // R8: servicing clears the first-expiry record
        do_reset();
        wr(4'd4, 2'b11, 16'h0000);
        wait_n(4*DIV);
        chk("R8 first expiry", {15'h0, nmi_pulse}, 16'h1);
        wr(4'd0, 2'b11, 16'h0000);
        wait_n(4*DIV);
        chk("R8 next expiry pulses", {15'h0, nmi_pulse}, 16'h1);
        chk("R8 no reset after service", {15'h0, reset_req}, 16'h0);

        // R7 with strap: pulse continues, no reset
        do_reset();
        strap_noreboot = 1'b1; smi_route_en = 1'b1;
        wr(4'd4, 2'b11, 16'h0000);
        wait_n(4*DIV);
        chk("R6 smi on expiry", {15'h0, smi_pulse}, 16'h1);
        rd(4'd3, v); chk("R7 no second status yet", v, 16'h0000);
        wait_n(4*DIV);
        chk("R7 strap second smi", {15'h0, smi_pulse}, 16'h1);
        chk("R7 strap no reset", {15'h0, reset_req}, 16'h0);
        rd(4'd3, v); chk("R7 strap status2", v, 16'h0006);
        strap_noreboot = 1'b0; smi_route_en = 1'b0;

        // R10 / R4: control writes start and stop the timer
        do_reset();
        wr(4'd4, 2'b11, 16'h0000);
        wait_n(6);
        wr(4'd4, 2'b11, 16'h0800);
        rd(4'd0, held); chk("R10 halt freezes count", held, 16'h0003);
        pulses = 0;
        wait_n(40);
        rd(4'd0, v); chk("R10 count stays halted", v, held);
        chk("R10 no pulse halted", pulses[15:0], 16'h0);
        wr(4'd4, 2'b11, 16'h0000);
        rd(4'd0, v); chk("R10 restart reloads", v, 16'h0004);
        wr(4'd9, 2'b11, 16'h0001);
        wr(4'd4, 2'b11, 16'h0000);
        pulses = 0;
        wait_n(40);
        rd(4'd0, v); chk("R4 start of 1 does not run", v, 16'h0004);
        chk("R4 no pulse", pulses[15:0], 16'h0);
        wr(4'd0, 2'b11, 16'h0021);
        rd(4'd0, v); chk("R5 stored when not runnable", v, 16'h0021);

        // R9: lock is sticky
        wr(4'd4, 2'b11, 16'h1800);
        chk("R9 lock out set", {15'h0, lock_out}, 16'h1);
        wr(4'd4, 2'b11, 16'h0000);
        rd(4'd4, v); chk("R9 lock survives write", v, 16'h1000);
        chk("R9 lock out held", {15'h0, lock_out}, 16'h1);
        do_reset();
        chk("R9 reset clears lock", {15'h0, lock_out}, 16'h0);

        // R11: mailbox ports
        wr(4'd1, 2'b01, 16'h005A);
        chk("R11 smi after mailbox-in", {15'h0, smi_pulse}, 16'h1);
        wait_n(1);
        chk("R11 smi single cycle", {15'h0, smi_pulse}, 16'h0);
        rd(4'd2, v); chk("R11 sw smi status", v, 16'h0002);
        wr(4'd1, 2'b10, 16'hC300);
        chk("R11 no smi for mailbox-out", {15'h0, smi_pulse}, 16'h0);
        rd(4'd2, v); chk("R11 mailbox-out status", v, 16'h0006);
        rd(4'd1, v); chk("R11 mailbox bytes", v, 16'hC35A);

        finish_run();
    end
endmodule